// File: doc/BRIEF.md
# Reset and Boot-Vector Sequencer

This block brings a small 8-bit-style processor core out of reset. It synchronizes an active-low external reset input, and after that input is released it holds the core through a fixed stabilization wait, measured in clock cycles. It then reads a two-byte boot word from program memory over a simple synchronous read port with one cycle of read latency. The first byte supplies the upper program-counter bits and two bank-enable flags. The second byte supplies the lower eight program-counter bits.

Once both bytes are captured, the block raises a run-enable level. In that same first cycle it also gives a one-cycle load strobe. On that strobe the core takes the program counter and flags, and it writes its fixed reset values: skip and interrupt-status flags cleared, bank selects cleared, timer count 0, timer modulo FFH, timer mode 0, and timer output enable and output flip-flop cleared. A registered status bit tells the core whether the last reset came from standby mode. The core uses it to decide whether the carry flag, general registers and data memory are preserved. After a standby reset, data memory is kept except for a small scratch window.

Top module: `rbs_boot_seq`

## Requirements
- R1: `rst_in_n` is active low. It clears the synchronizer at once, and its release reaches the sequencer only after `SYNC_STAGES` (default 2) rising clock edges.
- R2: If `rst_in_n` is released before rising edge 1, then `mem_rd_o` and `run_en_o` stay low for the cycles following edges 1 through `WAIT_CYCLES`+2. The first read is seen in the cycle following edge `WAIT_CYCLES`+3.
- R3: The boot word is read with `mem_rd_o` high for exactly two consecutive cycles. `mem_addr_o` is 0 in the first of these cycles and 1 in the second. Each byte is taken from `mem_rdata_i` one cycle after its read.
- R4: `pc_o[13:8]` equals bits 5..0 of the byte at address 0, and `pc_o[7:0]` equals the byte at address 1.
- R5: `rbe_o` equals bit 6 of the byte at address 0, and `mbe_o` equals bit 7 of that byte.
- R6: `run_en_o` rises two cycles after the second read cycle, which is the cycle after both bytes are captured. `boot_load_o` is high in that cycle only.
- R7: If reset is asserted again at any point (during the wait, the fetch or the run), `run_en_o` and `mem_rd_o` are low after the next rising edge. The next release then runs the full wait again with the same timing as R2.
- R8: While the synchronized reset is asserted, `run_en_o`, `boot_load_o` and `mem_rd_o` are low, and `pc_o`, `mbe_o` and `rbe_o` read 0.
- R9: `from_standby_o` holds the value of `standby_i` from the last cycle in which the synchronized reset was asserted. Changes on `standby_i` at any other time have no effect on it.
- R10: While `run_en_o` is high, `pc_o`, `mbe_o` and `rbe_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in_n | input | 1 | External reset, active low, asynchronous |
| standby_i | input | 1 | High while the core is in standby mode |
| mem_rd_o | output | 1 | Program memory read request |
| mem_addr_o | output | AW (14) | Program memory read address |
| mem_rdata_i | input | DW (8) | Read data, valid one cycle after the request |
| run_en_o | output | 1 | Core may execute |
| boot_load_o | output | 1 | One-cycle strobe: load PC, flags and fixed reset values |
| pc_o | output | PCW (14) | Boot program counter |
| mbe_o | output | 1 | Memory-bank enable flag |
| rbe_o | output | 1 | Register-bank enable flag |
| from_standby_o | output | 1 | Last reset arrived while in standby mode |

## Verification
A state machine that leaves the wait one cycle early or one cycle late shifts the first read request. That shift is visible at `mem_rd_o` exactly `WAIT_CYCLES`+3 edges after release, so timing faults appear within a few cycles of the wait ending. If the high byte is captured in the wrong cycle, `pc_o` and the flags disagree with the memory contents on the first run cycle. This is made plain by driving non-boot filler data on the read port whenever no read is pending. A missed restart or a wrong standby capture shows up at the next release or at the next run cycle.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_FETCH0 = 3'd2,
        ST_FETCH1 = 3'd3,
        ST_LOAD   = 3'd4,
        ST_RUN    = 3'd5
    } rbs_state_e;
endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = 1'b1;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rel_q = chain_q[STAGES-1];
endmodule

// File: rtl/rbs_settle.sv
module rbs_settle #(
    parameter int CYCLES = 131072,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic clear,
    input  logic active,
    output logic done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = active && (cnt_q == CW'(CYCLES - 1));
        cnt_d = (clear || !active) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;
endmodule

// File: rtl/rbs_bootword.sv
module rbs_bootword #(
    parameter int PCW = 14,
    parameter int DW  = 8,
    localparam int HB = PCW - DW
) (
    input  logic [DW-1:0]  hi_byte,
    input  logic [DW-1:0]  lo_byte,
    output logic [PCW-1:0] pc,
    output logic           mbe,
    output logic           rbe
);
    always_comb begin
        pc  = {hi_byte[HB-1:0], lo_byte};
        mbe = hi_byte[DW-1];
        rbe = hi_byte[DW-2];
    end
endmodule

// File: rtl/rbs_boot_seq.sv
module rbs_boot_seq
    import rbs_pkg::*;
#(
    parameter int WAIT_CYCLES = 131072,
    parameter int SYNC_STAGES = 2,
    parameter int PCW         = 14,
    parameter int DW          = 8,
    parameter int AW          = 14
) (
    input  logic           clk,
    input  logic           rst_in_n,
    input  logic           standby_i,
    output logic           mem_rd_o,
    output logic [AW-1:0]  mem_addr_o,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           run_en_o,
    output logic           boot_load_o,
    output logic [PCW-1:0] pc_o,
    output logic           mbe_o,
    output logic           rbe_o,
    output logic           from_standby_o
);
    typedef struct packed {
        rbs_state_e     state;
        logic [DW-1:0]  hi;
        logic [PCW-1:0] pc;
        logic           mbe;
        logic           rbe;
        logic           run;
        logic           load;
        logic           stby;
    } seq_t;

    seq_t seq_d, seq_q;

    logic           rst_sync;
    logic           wait_done;
    logic [PCW-1:0] dec_pc;
    logic           dec_mbe;
    logic           dec_rbe;

    rbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (rst_in_n),
        .rel_q  (rst_sync)
    );

    rbs_settle #(.CYCLES(WAIT_CYCLES)) u_settle (
        .clk    (clk),
        .clear  (!rst_sync),
        .active (seq_q.state == ST_WAIT),
        .done   (wait_done)
    );

    rbs_bootword #(.PCW(PCW), .DW(DW)) u_word (
        .hi_byte (seq_q.hi),
        .lo_byte (mem_rdata_i),
        .pc      (dec_pc),
        .mbe     (dec_mbe),
        .rbe     (dec_rbe)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.load = 1'b0;
        if (!rst_sync) begin
            seq_d.state = ST_HOLD;
            seq_d.hi    = '0;
            seq_d.pc    = '0;
            seq_d.mbe   = 1'b0;
            seq_d.rbe   = 1'b0;
            seq_d.run   = 1'b0;
            seq_d.stby  = standby_i;
        end else begin
            unique case (seq_q.state)
                ST_HOLD:   seq_d.state = ST_WAIT;
                ST_WAIT:   if (wait_done) seq_d.state = ST_FETCH0;
                ST_FETCH0: seq_d.state = ST_FETCH1;
                ST_FETCH1: begin
                    seq_d.hi    = mem_rdata_i;
                    seq_d.state = ST_LOAD;
                end
                ST_LOAD: begin
                    seq_d.pc    = dec_pc;
                    seq_d.mbe   = dec_mbe;
                    seq_d.rbe   = dec_rbe;
                    seq_d.run   = 1'b1;
                    seq_d.load  = 1'b1;
                    seq_d.state = ST_RUN;
                end
                ST_RUN:    seq_d.state = ST_RUN;
                default:   seq_d.state = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) seq_q <= seq_d;

    assign mem_rd_o       = (seq_q.state == ST_FETCH0) || (seq_q.state == ST_FETCH1);
    assign mem_addr_o     = (seq_q.state == ST_FETCH1) ? AW'(1) : '0;
    assign run_en_o       = seq_q.run;
    assign boot_load_o    = seq_q.load;
    assign pc_o           = seq_q.pc;
    assign mbe_o          = seq_q.mbe;
    assign rbe_o          = seq_q.rbe;
    assign from_standby_o = seq_q.stby;
endmodule

// File: rtl/rbs_boot_chk.sv
module rbs_boot_chk #(
    parameter int WAIT_CYCLES = 131072,
    parameter int PCW         = 14,
    parameter int AW          = 14,
    localparam int TW         = $clog2(WAIT_CYCLES + 1) + 3
) (
    input logic           clk,
    input logic           rst_in_n,
    input logic           rst_sync,
    input logic           mem_rd_o,
    input logic [AW-1:0]  mem_addr_o,
    input logic           run_en_o,
    input logic           boot_load_o,
    input logic [PCW-1:0] pc_o,
    input logic           from_standby_o
);
    logic [TW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n)        since_q <= '0;
        else if (!rst_sync)   since_q <= '0;
        else if (since_q != '1) since_q <= since_q + TW'(1);
    end

    p_wait_len_r2: assert property (@(posedge clk) disable iff (!rst_in_n)
        $rose(run_en_o) |-> since_q == TW'(WAIT_CYCLES + 4));

    p_second_addr_r3: assert property (@(posedge clk) disable iff (!rst_in_n)
        mem_rd_o && $past(mem_rd_o) |-> mem_addr_o == AW'(1));

    p_no_read_run_r3: assert property (@(posedge clk) disable iff (!rst_in_n)
        mem_rd_o |-> !run_en_o);

    p_load_pulse_r6: assert property (@(posedge clk) disable iff (!rst_in_n)
        boot_load_o |=> !boot_load_o);

    p_rise_with_load_r6: assert property (@(posedge clk) disable iff (!rst_in_n)
        $rose(run_en_o) |-> boot_load_o);

    p_held_r8: assert property (@(posedge clk) disable iff (!rst_in_n)
        !rst_sync |=> !run_en_o && !mem_rd_o);

    p_stby_kept_r9: assert property (@(posedge clk) disable iff (!rst_in_n)
        rst_sync && $past(rst_sync) |-> $stable(from_standby_o));

    p_pc_steady_r10: assert property (@(posedge clk) disable iff (!rst_in_n)
        run_en_o && $past(run_en_o) |-> $stable(pc_o));
endmodule

bind rbs_boot_seq rbs_boot_chk #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .PCW         (PCW),
    .AW          (AW)
) u_chk (
    .clk            (clk),
    .rst_in_n       (rst_in_n),
    .rst_sync       (rst_sync),
    .mem_rd_o       (mem_rd_o),
    .mem_addr_o     (mem_addr_o),
    .run_en_o       (run_en_o),
    .boot_load_o    (boot_load_o),
    .pc_o           (pc_o),
    .from_standby_o (from_standby_o)
);

// File: tb/sim_rbs_boot_seq.sv
`timescale 1ns/1ps
module sim_rbs_boot_seq;
    localparam int W = 5;

    logic        clk = 1'b0;
    logic        rst_in_n = 1'b0;
    logic        standby_i = 1'b0;
    logic        mem_rd_o;
    logic [13:0] mem_addr_o;
    logic [7:0]  mem_rdata_i = 8'h00;
    logic        run_en_o, boot_load_o, mbe_o, rbe_o, from_standby_o;
    logic [13:0] pc_o;

    logic [7:0] rom0 = 8'h00, rom1 = 8'h00;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    rbs_boot_seq #(.WAIT_CYCLES(W)) u0 (
        .clk(clk), .rst_in_n(rst_in_n), .standby_i(standby_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .run_en_o(run_en_o), .boot_load_o(boot_load_o), .pc_o(pc_o),
        .mbe_o(mbe_o), .rbe_o(rbe_o), .from_standby_o(from_standby_o)
    );

    // program memory model: one-cycle read latency, filler when idle
    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= (mem_addr_o == 14'd0) ? rom0 :
                                     (mem_addr_o == 14'd1) ? rom1 : 8'hA5;
        else          mem_rdata_i <= 8'h3C ^ rom0;
    end

    function automatic logic [13:0] exp_pc(logic [7:0] b0, logic [7:0] b1);
        return {b0[5:0], b1};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_held();
        chk(run_en_o == 1'b0 && mem_rd_o == 1'b0 && boot_load_o == 1'b0, "R8",
            "outputs idle in reset", {run_en_o, mem_rd_o, boot_load_o}, 0);
        chk(pc_o == 14'd0 && mbe_o == 1'b0 && rbe_o == 1'b0, "R8",
            "pc/flags cleared", {pc_o, mbe_o, rbe_o}, 0);
    endtask

    task automatic enter_reset();
        rst_in_n = 1'b0;
        step();
        chk(run_en_o == 1'b0 && mem_rd_o == 1'b0, "R7", "drop after reassert",
            {run_en_o, mem_rd_o}, 0);
        step();
        step();
        check_held();
    endtask

    // release reset and follow the full boot; leaves the core running
    task automatic boot_run(logic [7:0] b0, logic [7:0] b1, logic stby);
        logic [13:0] pc_first;
        pc_first = '0;
        rom0 = b0;
        rom1 = b1;
        standby_i = stby;
        step();
        rst_in_n = 1'b1;
        for (int k = 1; k <= W + 7; k++) begin
            step();
            if (k == 2) standby_i = ~stby;  // after sync release: must be ignored
            if (k <= W + 2) begin
                chk(!mem_rd_o && !run_en_o, (k <= 2) ? "R1" : "R2", "idle during wait",
                    {mem_rd_o, run_en_o}, 0);
            end else if (k == W + 3) begin
                chk(mem_rd_o && mem_addr_o == 14'd0, "R3", "first read addr 0",
                    {mem_rd_o, mem_addr_o}, {1'b1, 14'd0});
            end else if (k == W + 4) begin
                chk(mem_rd_o && mem_addr_o == 14'd1, "R3", "second read addr 1",
                    {mem_rd_o, mem_addr_o}, {1'b1, 14'd1});
            end else if (k == W + 5) begin
                chk(!mem_rd_o && !run_en_o, "R6", "capture cycle, not running",
                    {mem_rd_o, run_en_o}, 0);
            end else if (k == W + 6) begin
                chk(run_en_o && boot_load_o, "R6", "run and load strobe",
                    {run_en_o, boot_load_o}, 3);
                chk(pc_o == exp_pc(b0, b1), "R4", "boot pc", pc_o, exp_pc(b0, b1));
                chk(mbe_o == b0[7] && rbe_o == b0[6], "R5", "bank flags",
                    {mbe_o, rbe_o}, {b0[7], b0[6]});
                chk(from_standby_o == stby, "R9", "standby source", from_standby_o, stby);
                pc_first = pc_o;
            end else begin
                chk(run_en_o && !boot_load_o, "R6", "single load pulse",
                    {run_en_o, boot_load_o}, 2);
                chk(pc_o == pc_first, "R10", "pc steady", pc_o, pc_first);
            end
        end
        standby_i = stby;
        step();
        standby_i = ~stby;
        step();
        chk(from_standby_o == stby, "R9", "standby ignored while running",
            from_standby_o, stby);
        chk(pc_o == pc_first && mbe_o == b0[7] && rbe_o == b0[6], "R10", "run state steady",
            {pc_o, mbe_o, rbe_o}, {pc_first, b0[7], b0[6]});
    endtask

    // release, then abort after j cycles
    task automatic abort_after(int j, logic [7:0] b0);
        rom0 = b0;
        step();
        rst_in_n = 1'b1;
        for (int k = 1; k <= j; k++) step();
        enter_reset();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step();
        step();
        check_held();

        // directed corners
        boot_run(8'hFF, 8'hFF, 1'b1);
        enter_reset();
        boot_run(8'h00, 8'h00, 1'b0);
        enter_reset();
        boot_run(8'h80, 8'h01, 1'b0);
        enter_reset();
        boot_run(8'h7F, 8'hFE, 1'b1);
        enter_reset();

        // aborts in the wait, in each fetch cycle and in the capture cycle; then full restart
        for (int j = 1; j <= W + 5; j++) begin
            abort_after(j, 8'hC3);
            boot_run(8'h5A, 8'hA5, j[0]);
            enter_reset();
        end

        // random boot words and standby sources
        for (int n = 0; n < 24; n++) begin
            logic [7:0] r0, r1;
            logic       s;
            r0 = 8'($urandom());
            r1 = 8'($urandom());
            s  = 1'($urandom());
            boot_run(r0, r1, s);
            repeat (1 + ($urandom() % 4)) step();
            enter_reset();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule